// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block holds a small word of single-bit flags, each of which can be written on its own by giving its index on an address bus. Two active-low control inputs, an enable and a conditional clear, together select one of four modes:

- write one bit;
- keep everything;
- route the data bit to one output while clearing the rest;
- clear the whole word.

With the data input tied high, the routing mode acts as a one-hot address decoder. That lets one block serve as a serial-to-parallel flag register, a demultiplexer or a decoder.

The model is synchronous. All inputs are sampled on the rising edge of the system clock, and the outputs come straight from the storage flops, so every change shows one clock after the inputs that caused it. A synchronous active-high system reset clears the storage independently of the functional clear input. The address width is a parameter, and the word width is two to the power of that width.

Top module: `addr_bit_latch`

## Requirements
- R1: With enable low and clear high (write mode), the addressed bit takes the data input and every other bit keeps its stored value.
- R2: With enable high and clear high (hold mode), all bits keep their values whatever the data and address inputs do, including changes of several address bits at once.
- R3: With enable low and clear low (route mode), the addressed output equals the data input and all other outputs are low. With data high, exactly one output is set.
- R4: With enable high and clear low (clear mode), every output is low regardless of address and data.
- R5: The address is an unsigned binary index, least significant bit first: address value k selects output bit k, from 0 up to the word width minus one.
- R6: The system reset input, active high and synchronous, clears all stored bits to zero at the next rising edge, whatever the mode inputs are.
- R7: Bits cleared by route or clear mode stay stored as zero after the block returns to hold mode.
- R8: Each output reflects the inputs sampled at the most recent rising clock edge, so a write shows on the outputs exactly one clock after it is applied.
- R9: The data and address present in the last write-mode cycle before enable goes high remain captured in that addressed bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| srst | input | 1 | Synchronous system reset, active high |
| addr_i | input | ADDR_W | Bit index to write or route to |
| data_i | input | 1 | Data bit |
| en_n_i | input | 1 | Enable, active low |
| clr_n_i | input | 1 | Conditional clear, active low |
| q_o | output | 2**ADDR_W | Stored word, active high |

## Verification
The bench builds the block with the default three-bit address, giving an eight-bit word. At that size every address can be visited in write mode and in route mode, and the one-hot pattern can be walked from bit 0 to bit 7. A long random run then mixes all four modes and system resets, so each mode follows each other mode many times. Those transitions expose stale-bit and wrong-mask faults that directed runs might miss.

// File: rtl/abl_pkg.sv
package abl_pkg;

    // Operating mode, decoded from the two active-low controls
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_ROUTE = 2'd2,
        MODE_CLEAR = 2'd3
    } abl_mode_e;

    // State held by one storage cell
    typedef struct packed {
        logic val;
    } cell_state_t;

endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
    import abl_pkg::*;
(
    input  logic      en_n,
    input  logic      clr_n,
    output abl_mode_e mode
);

    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_ROUTE;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/abl_addr_dec.sv
module abl_addr_dec #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic [(1<<ADDR_W)-1:0] sel
);

    localparam int NBITS = 1 << ADDR_W;

    for (genvar i = 0; i < NBITS; i++) begin : g_sel
        assign sel[i] = (addr == i[ADDR_W-1:0]);
    end

endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
    import abl_pkg::*;
(
    input  logic      clk,
    input  logic      srst,
    input  abl_mode_e mode,
    input  logic      sel,
    input  logic      data,
    output logic      q
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_WRITE: if (sel) st_d.val = data;
            MODE_HOLD:  st_d.val = st_q.val;
            MODE_ROUTE: st_d.val = sel & data;
            MODE_CLEAR: st_d.val = 1'b0;
            default:    st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign q = st_q.val;

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
    import abl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      srst,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      data_i,
    input  logic                      en_n_i,
    input  logic                      clr_n_i,
    output logic [(1<<ADDR_W)-1:0]    q_o
);

    localparam int NBITS = 1 << ADDR_W;

    abl_mode_e        mode_w;
    logic [NBITS-1:0] sel_w;

    abl_mode_dec u_mode_dec (
        .en_n  (en_n_i),
        .clr_n (clr_n_i),
        .mode  (mode_w)
    );

    abl_addr_dec #(.ADDR_W(ADDR_W)) u_addr_dec (
        .addr (addr_i),
        .sel  (sel_w)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        abl_bit_cell u_cell (
            .clk  (clk),
            .srst (srst),
            .mode (mode_w),
            .sel  (sel_w[i]),
            .data (data_i),
            .q    (q_o[i])
        );
    end

    // R1
    write_bit_chk: assert property (@(posedge clk) disable iff (srst)
        (!en_n_i && clr_n_i) |=> (q_o[$past(addr_i)] == $past(data_i)));

    // R1
    write_others_chk: assert property (@(posedge clk) disable iff (srst)
        (!en_n_i && clr_n_i) |=> (((q_o ^ $past(q_o)) & ~$past(sel_w)) == '0));

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (srst)
        (en_n_i && clr_n_i) |=> $stable(q_o));

    // R3
    route_onehot_chk: assert property (@(posedge clk) disable iff (srst)
        (!en_n_i && !clr_n_i) |=> ($onehot0(q_o) && ($countones(q_o) == $past(data_i))));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (srst)
        (en_n_i && !clr_n_i) |=> (q_o == '0));

    // R6
    sys_reset_chk: assert property (@(posedge clk)
        srst |=> (q_o == '0));

endmodule

// File: tb/addr_bit_latch_bench.sv
module addr_bit_latch_bench;

    localparam int ADDR_W = 3;
    localparam int NBITS  = 1 << ADDR_W;

    typedef struct {
        logic [NBITS-1:0] exp;
        string            tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              srst = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              data_i = 1'b0;
    logic              en_n_i = 1'b1;
    logic              clr_n_i = 1'b1;
    logic [NBITS-1:0]  q_o;

    logic [NBITS-1:0]  model_q = '0;
    sb_item_t          sb_q[$];
    int                n_checks = 0;
    int                n_fails  = 0;
    bit                finished = 1'b0;

    always #4 clk = ~clk;

    addr_bit_latch #(.ADDR_W(ADDR_W)) u_addr_bit_latch (
        .clk     (clk),
        .srst    (srst),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .en_n_i  (en_n_i),
        .clr_n_i (clr_n_i),
        .q_o     (q_o)
    );

    // Driver: apply one cycle of stimulus and push the expected word
    task automatic drive(input logic rst, input logic en_n, input logic clr_n,
                         input logic [ADDR_W-1:0] a, input logic d, input string tag);
        sb_item_t it;
        @(negedge clk);
        srst = rst; en_n_i = en_n; clr_n_i = clr_n; addr_i = a; data_i = d;
        if (rst) begin
            model_q = '0;
        end else begin
            case ({en_n, clr_n})
                2'b01: model_q[a] = d;
                2'b11: model_q = model_q;
                2'b00: begin model_q = '0; model_q[a] = d; end
                default: model_q = '0;
            endcase
        end
        it.exp = model_q;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: result of the stimulus appears after the next rising edge (R8)
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (q_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s: q_o=%b expected=%b", it.tag, q_o, it.exp);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        drive(1, 1, 1, 0, 0, "R6 reset");
        drive(1, 0, 1, 3, 1, "R6 reset overrides write");

        // R1 R5 R8: write each address in turn, walking ones
        for (int a = 0; a < NBITS; a++)
            drive(0, 0, 1, a[ADDR_W-1:0], 1, "R5 R8 write addr");
        // R1: clear even bits, odd bits keep
        for (int a = 0; a < NBITS; a += 2)
            drive(0, 0, 1, a[ADDR_W-1:0], 0, "R1 write zero");

        // R2: hold with multi-bit address swings and data toggles
        drive(0, 1, 1, 3'b000, 1, "R2 hold");
        drive(0, 1, 1, 3'b111, 0, "R2 hold addr swing");
        drive(0, 1, 1, 3'b010, 1, "R2 hold");
        drive(0, 1, 1, 3'b101, 1, "R2 hold addr swing");

        // R9: last write before enable rises is captured
        drive(0, 0, 1, 3'd4, 1, "R9 write");
        drive(0, 0, 1, 3'd4, 0, "R9 write final");
        drive(0, 1, 1, 3'd1, 1, "R9 enable high");
        drive(0, 1, 1, 3'd6, 1, "R9 hold");

        // R3: decoder walk with data high, then route with data low
        for (int a = 0; a < NBITS; a++)
            drive(0, 0, 0, a[ADDR_W-1:0], 1, "R3 decode");
        drive(0, 0, 0, 3'd5, 0, "R3 route zero");
        drive(0, 0, 0, 3'd2, 1, "R3 route one");
        // R7: cleared bits stay zero in hold
        drive(0, 1, 1, 3'd7, 1, "R7 hold after route");
        drive(0, 1, 1, 3'd0, 0, "R7 hold after route");

        // R4: clear mode after filling
        for (int a = 0; a < NBITS; a++)
            drive(0, 0, 1, a[ADDR_W-1:0], 1, "R1 fill");
        drive(0, 1, 0, 3'd3, 1, "R4 clear");
        drive(0, 1, 0, 3'd6, 0, "R4 clear");
        drive(0, 1, 1, 3'd1, 1, "R7 hold after clear");

        // Random mix of all modes and occasional system reset
        for (int i = 0; i < 4000; i++) begin
            logic rr;
            logic [1:0] m;
            rr = ($urandom_range(0, 63) == 0);
            m  = 2'($urandom_range(0, 3));
            drive(rr, m[1], m[0], ADDR_W'($urandom_range(0, NBITS-1)),
                  1'($urandom_range(0, 1)), "R1 R2 R3 R4 random");
        end

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule